// File: doc/BRIEF.md
# YCbCr 4:2:2 Video Output Formatter

This block turns a stream of 10-bit 4:4:4 YCbCr pixels, with their horizontal, vertical and field timing flags, into 4:2:2 video. A mode input picks one of two output forms. The first is a two-lane form: one lane carries luma and a second lane carries Cb and Cr in turn, both at the pixel rate. The second is a single multiplexed lane at twice the pixel rate, as defined by ITU-R BT.656. On that lane the block can insert start-of-line and end-of-line timing reference codes. It can also overwrite the blanking interval with fixed luma and chroma codes.

The block runs on one clock at twice the pixel rate. A pixel strobe marks every other cycle as an input pixel slot. Configuration values are plain input ports that are held static while a line is in flight. Input pixels pass through a two-pixel delay line. This delay leaves room for the four-word start code ahead of the first active sample on the multiplexed lane.

Top module: `yc422_fmt`

## Requirements
- R1: When `mode_656_i` is 1 the luma lane carries the multiplexed stream, and after every strobe cycle the chroma lane reads 0. When `mode_656_i` is 0 the two-lane form is produced.
- R2: In two-lane mode both lanes change only on the edge that ends a strobe cycle. After the strobe for input pixel t, the luma lane shows the processed luma of pixel t-2, and it holds that value through the following non-strobe cycle.
- R3: Pixel parity restarts at 0 on a pixel whose `href_i` is 1 when the previous pixel's was 0; otherwise it alternates, and the first pixel after reset has parity 0. The chroma sample of a pixel is its Cb when parity is 0 and its Cr when parity is 1. In two-lane mode this sample appears on the chroma lane at the same time as the pixel's luma.
- R4: In multiplexed mode each pixel slot emits two words: first the pixel's chroma sample, then its luma. Over a pixel pair this gives the order Cb, Y, Cr, Y. The first word appears in the cycle after the strobe and the second word in the cycle after that.
- R5: With `ref_en_i` at 1 in multiplexed mode, a start code of 3FF, 000, 000, XY (H=0) fills the four words immediately before the first active sample of a line.
- R6: With `ref_en_i` at 1 in multiplexed mode, an end code of 3FF, 000, 000, XY (H=1) fills the four words immediately after the last active sample. Lines are separated by at least four inactive pixels.
- R7: The XY word has these bits: bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H, and bits 1..0 = 0.
- R8: F and V are captured from the pixel that starts the line, with F = `fref_i` and V = NOT `vref_i`. Both the start and the end codes of that line use the captured values, and both are 0 after reset.
- R9: A pixel is active when both `href_i` and `vref_i` are 1. With `blank_en_i` at 1, an inactive pixel's luma is replaced by `blank_y_i` and its chroma sample by `blank_c_i`.
- R10: With `blank_en_i` at 0, inactive pixels pass through unchanged, reserved values included.
- R11: Active luma and chroma values from 000 to 003 are output as 004, and values from 3FC to 3FF are output as 3FB.
- R12: With `ref_en_i` at 0, no code is inserted, and the words at those positions carry the delayed pixel data.
- R13: While reset is held, the luma lane reads 040 and the chroma lane reads 200. The delay line is filled with inactive pixels carrying those codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_stb_i | input | 1 | Input pixel slot, high every other cycle |
| y_i | input | 10 | Luma of the input pixel |
| cb_i | input | 10 | Cb of the input pixel |
| cr_i | input | 10 | Cr of the input pixel |
| href_i | input | 1 | Horizontal active flag of the input pixel |
| vref_i | input | 1 | Vertical active flag of the input pixel |
| fref_i | input | 1 | Field flag of the input pixel |
| mode_656_i | input | 1 | 1 selects the multiplexed lane, 0 selects two lanes |
| ref_en_i | input | 1 | Enables insertion of the timing reference codes |
| blank_en_i | input | 1 | Enables replacement of blanking samples |
| blank_y_i | input | 10 | Fill code for luma positions |
| blank_c_i | input | 10 | Fill code for chroma positions |
| lane_y_o | output | 10 | Luma lane, or the multiplexed stream |
| lane_c_o | output | 10 | Interleaved Cb/Cr lane |

## Verification
If the parity flip-flop is wrong, the chroma lane carries Cr where Cb belongs. This shows two pixels after the line starts and persists for the rest of the line. If the href history is wrong, the reference codes move or vanish. A shifted code overwrites a first or last active sample on the multiplexed lane within two pixel slots of the line edge. A stale captured F or V bit corrupts both the XY word and its protection bits on the next code. The bench sweeps lines of odd and even length across all four F/V combinations and both modes. It compares every output word with a model built from the requirements.

// File: rtl/yc422_pkg.sv
package yc422_pkg;

  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_SAV  = 2'd1,
    SLOT_EAV  = 2'd2
  } slot_e;

  // upper eight bits of the XY word: 1, F, V, H, then protection bits
  function automatic logic [7:0] xy_hi(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/yc422_pix_sel.sv
module yc422_pix_sel #(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] cb_i,
  input  logic [DW-1:0] cr_i,
  input  logic          href_i,
  input  logic          vref_i,
  input  logic          blank_en_i,
  input  logic [DW-1:0] blank_y_i,
  input  logic [DW-1:0] blank_c_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o,
  output logic          act_o
);

  localparam logic [DW-1:0] CLIP_LO = DW'(4);
  localparam logic [DW-1:0] CLIP_HI = {DW{1'b1}} - DW'(4);

  function automatic logic [DW-1:0] clip_f(input logic [DW-1:0] x);
    if (x < CLIP_LO)      return CLIP_LO;
    else if (x > CLIP_HI) return CLIP_HI;
    else                  return x;
  endfunction

  logic          href_q;
  logic          par_q;
  logic          par_cur;
  logic [DW-1:0] c_raw;

  // parity restarts on the first active pixel of a line
  assign par_cur = (href_i && !href_q) ? 1'b0 : ~par_q;
  assign c_raw   = par_cur ? cr_i : cb_i;
  assign act_o   = href_i & vref_i;

  always_comb begin
    if (act_o) begin
      y_o = clip_f(y_i);
      c_o = clip_f(c_raw);
    end else if (blank_en_i) begin
      y_o = blank_y_i;
      c_o = blank_c_i;
    end else begin
      y_o = y_i;
      c_o = c_raw;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      href_q <= 1'b0;
      par_q  <= 1'b1;
    end else if (stb_i) begin
      href_q <= href_i;
      par_q  <= par_cur;
    end
  end

endmodule

// File: rtl/yc422_pix_pipe.sv
module yc422_pix_pipe #(
  parameter int unsigned   DW    = 10,
  parameter int unsigned   DEPTH = 2,
  parameter logic [DW-1:0] RST_Y = DW'(64),
  parameter logic [DW-1:0] RST_C = DW'(512)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] c_i,
  input  logic          act_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] c_o,
  output logic          act_o
);

  localparam int unsigned   PW    = 2 * DW + 1;
  localparam logic [PW-1:0] RST_W = {RST_Y, RST_C, 1'b0};

  logic [DEPTH-1:0][PW-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= RST_W;
    end else if (stb_i) begin
      stg_q[0] <= {y_i, c_i, act_i};
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign {y_o, c_o, act_o} = stg_q[DEPTH-1];

endmodule

// File: rtl/yc422_ref_ctl.sv
module yc422_ref_ctl
  import yc422_pkg::*;
#(
  parameter int unsigned DW = 10,
  parameter int unsigned PD = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic          href_i,
  input  logic          vref_i,
  input  logic          fref_i,
  input  logic          ref_en_i,
  output slot_e         slot_o,
  output logic          first_o,
  output logic [DW-1:0] xy_o
);

  localparam int unsigned HD = 2 * PD;

  // hist_q[i] holds href of pixel t-1-i
  logic [HD-1:0] hist_q;
  logic          line_f_q;
  logic          line_v_q;
  logic          data_off;
  logic          sav_slot;
  logic          eav_slot;
  logic          sav_first;
  logic          eav_first;

  assign data_off  = ~hist_q[PD-1];
  assign sav_slot  = data_off & (href_i | (|hist_q[PD-2:0]));
  assign eav_slot  = data_off & (|hist_q[HD-1:PD]);
  assign sav_first = href_i & ~hist_q[0];
  assign eav_first = hist_q[PD];

  always_comb begin
    slot_o  = SLOT_DATA;
    first_o = 1'b0;
    if (ref_en_i && sav_slot) begin
      slot_o  = SLOT_SAV;
      first_o = sav_first;
    end else if (ref_en_i && eav_slot) begin
      slot_o  = SLOT_EAV;
      first_o = eav_first;
    end
  end

  assign xy_o = DW'(xy_hi(line_f_q, line_v_q, slot_o == SLOT_EAV)) << (DW - 8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q   <= '0;
      line_f_q <= 1'b0;
      line_v_q <= 1'b0;
    end else if (stb_i) begin
      hist_q <= {hist_q[HD-2:0], href_i};
      if (sav_first) begin
        line_f_q <= fref_i;
        line_v_q <= ~vref_i;
      end
    end
  end

endmodule

// File: rtl/yc422_fmt.sv
module yc422_fmt
  import yc422_pkg::*;
#(
  parameter int unsigned   DW    = 10,
  parameter logic [DW-1:0] RST_Y = DW'(64),
  parameter logic [DW-1:0] RST_C = DW'(512)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_stb_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] cb_i,
  input  logic [DW-1:0] cr_i,
  input  logic          href_i,
  input  logic          vref_i,
  input  logic          fref_i,
  input  logic          mode_656_i,
  input  logic          ref_en_i,
  input  logic          blank_en_i,
  input  logic [DW-1:0] blank_y_i,
  input  logic [DW-1:0] blank_c_i,
  output logic [DW-1:0] lane_y_o,
  output logic [DW-1:0] lane_c_o
);

  localparam int unsigned   REF_WORDS  = 4;
  localparam int unsigned   WORDS_PIX  = 2;
  localparam int unsigned   PIPE_DEPTH = REF_WORDS / WORDS_PIX;
  localparam logic [DW-1:0] ALL_ONES   = {DW{1'b1}};

  logic [DW-1:0] sel_y, sel_c;
  logic          sel_act;
  logic [DW-1:0] pipe_y, pipe_c;
  logic          pipe_act;
  slot_e         ref_slot;
  logic          ref_first;
  logic [DW-1:0] ref_xy;
  logic [DW-1:0] word0, word1;
  logic [DW-1:0] y_q, c_q, pend_q;

  yc422_pix_sel #(.DW(DW)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (pix_stb_i),
    .y_i       (y_i),
    .cb_i      (cb_i),
    .cr_i      (cr_i),
    .href_i    (href_i),
    .vref_i    (vref_i),
    .blank_en_i(blank_en_i),
    .blank_y_i (blank_y_i),
    .blank_c_i (blank_c_i),
    .y_o       (sel_y),
    .c_o       (sel_c),
    .act_o     (sel_act)
  );

  yc422_pix_pipe #(
    .DW   (DW),
    .DEPTH(PIPE_DEPTH),
    .RST_Y(RST_Y),
    .RST_C(RST_C)
  ) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (pix_stb_i),
    .y_i   (sel_y),
    .c_i   (sel_c),
    .act_i (sel_act),
    .y_o   (pipe_y),
    .c_o   (pipe_c),
    .act_o (pipe_act)
  );

  yc422_ref_ctl #(.DW(DW), .PD(PIPE_DEPTH)) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (pix_stb_i),
    .href_i  (href_i),
    .vref_i  (vref_i),
    .fref_i  (fref_i),
    .ref_en_i(ref_en_i),
    .slot_o  (ref_slot),
    .first_o (ref_first),
    .xy_o    (ref_xy)
  );

  always_comb begin
    if (ref_slot == SLOT_DATA) begin
      word0 = pipe_c;
      word1 = pipe_y;
    end else if (ref_first) begin
      word0 = ALL_ONES;
      word1 = '0;
    end else begin
      word0 = '0;
      word1 = ref_xy;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q    <= RST_Y;
      c_q    <= RST_C;
      pend_q <= RST_Y;
    end else if (pix_stb_i) begin
      if (mode_656_i) begin
        y_q    <= word0;
        pend_q <= word1;
        c_q    <= '0;
      end else begin
        y_q <= pipe_y;
        c_q <= pipe_c;
      end
    end else if (mode_656_i) begin
      y_q <= pend_q;
    end
  end

  assign lane_y_o = y_q;
  assign lane_c_o = c_q;

endmodule

// File: rtl/yc422_fmt_chk.sv
module yc422_fmt_chk
  import yc422_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pix_stb_i,
  input logic          mode_656_i,
  input logic [DW-1:0] lane_y_o,
  input logic [DW-1:0] lane_c_o,
  input logic [DW-1:0] pipe_y,
  input logic [DW-1:0] pipe_c,
  input logic          pipe_act,
  input slot_e         ref_slot,
  input logic          ref_first
);

  localparam logic [DW-1:0] LO = DW'(4);
  localparam logic [DW-1:0] HI = {DW{1'b1}} - DW'(4);

  a_r2_lane_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_656_i && !pix_stb_i) |=> ($stable(lane_y_o) && $stable(lane_c_o)));

  a_r2_pipe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_stb_i |=> ($stable(pipe_y) && $stable(pipe_c) && $stable(pipe_act)));

  a_r1_c_lane_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_656_i && pix_stb_i) |=> (lane_c_o == '0));

  a_r11_active_clipped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_act |-> (pipe_y >= LO && pipe_y <= HI && pipe_c >= LO && pipe_c <= HI));

  a_r5_code_zero_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_656_i && pix_stb_i && ref_slot != SLOT_DATA && !ref_first) |=> (lane_y_o == '0));

endmodule

bind yc422_fmt yc422_fmt_chk #(.DW(DW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pix_stb_i (pix_stb_i),
  .mode_656_i(mode_656_i),
  .lane_y_o  (lane_y_o),
  .lane_c_o  (lane_c_o),
  .pipe_y    (pipe_y),
  .pipe_c    (pipe_c),
  .pipe_act  (pipe_act),
  .ref_slot  (ref_slot),
  .ref_first (ref_first)
);

// File: tb/yc422_fmt_tb_top.sv
module yc422_fmt_tb_top;

  localparam logic [9:0] RY = 10'h040;
  localparam logic [9:0] RC = 10'h200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       stb;
  logic [9:0] y, cb, cr;
  logic       href, vref, fref;
  logic       mode, ref_en, blank_en;
  logic [9:0] blank_y, blank_c;
  logic [9:0] lane_y, lane_c;

  always #4 clk = ~clk;

  yc422_fmt dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pix_stb_i (stb),
    .y_i       (y),
    .cb_i      (cb),
    .cr_i      (cr),
    .href_i    (href),
    .vref_i    (vref),
    .fref_i    (fref),
    .mode_656_i(mode),
    .ref_en_i  (ref_en),
    .blank_en_i(blank_en),
    .blank_y_i (blank_y),
    .blank_c_i (blank_c),
    .lane_y_o  (lane_y),
    .lane_c_o  (lane_c)
  );

  int checks = 0;
  int errors = 0;

  // model state
  logic       hq [1:4];
  logic       mpar;
  logic [9:0] my1, my2, mc1, mc2;
  string      ty1, ty2, tc1, tc2;
  logic       lf, lv;
  logic [15:0] lfsr;
  int          dcnt;

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] clipv(input logic [9:0] x);
    if (x < 10'h004) return 10'h004;
    if (x > 10'h3FB) return 10'h3FB;
    return x;
  endfunction

  function automatic logic [9:0] next_data();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dcnt++;
    case (dcnt % 9)
      0: return 10'h000;
      1: return 10'h3FF;
      2: return 10'h3FC;
      3: return 10'h003;
      default: return lfsr[9:0];
    endcase
  endfunction

  task automatic pix(input logic h, input logic v, input logic f);
    logic [9:0] iy, icb, icr, py, pc, cin, e0, e1, xy, hold_y, hold_c;
    logic       par, act, sav, eav, first, hb;
    string      tgy, tgc, tg0, tg1;
    iy  = next_data();
    icb = next_data();
    icr = next_data();
    // R3 parity, R9/R10/R11 processing
    par  = (h && !hq[1]) ? 1'b0 : ~mpar;
    mpar = par;
    cin  = par ? icr : icb;
    act  = h & v;
    if (act) begin
      py = clipv(iy); pc = clipv(cin);
      tgy = (py != iy) ? "R11" : "R2";
      tgc = (pc != cin) ? "R11" : "R3";
    end else if (blank_en) begin
      py = blank_y; pc = blank_c; tgy = "R9"; tgc = "R9";
    end else begin
      py = iy; pc = cin; tgy = "R10"; tgc = "R10";
    end
    // R5/R6 slot placement on the delayed data
    sav   = ref_en && !hq[2] && (h || hq[1]);
    eav   = ref_en && !sav && !hq[2] && (hq[3] || hq[4]);
    first = sav ? (h && !hq[1]) : hq[3];
    hb    = eav;
    xy    = {1'b1, lf, lv, hb, lv ^ hb, lf ^ hb, lf ^ lv, lf ^ lv ^ hb, 2'b00};
    if (sav || eav) begin
      e0  = first ? 10'h3FF : 10'h000;
      e1  = first ? 10'h000 : xy;
      tg0 = sav ? "R5" : "R6";
      tg1 = first ? tg0 : (sav ? "R8" : "R7");
    end else begin
      e0  = mc2; e1 = my2;
      tg0 = ref_en ? "R4" : "R12";
      tg1 = ref_en ? "R4" : "R12";
    end
    if (h && !hq[1]) begin
      lf = f;
      lv = ~v;
    end
    y = iy; cb = icb; cr = icr; href = h; vref = v; fref = f; stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (mode) begin
      chk(tg0, lane_y, e0);
      chk("R1", lane_c, 10'h000);
    end else begin
      chk(ty2, lane_y, my2);
      chk(tc2, lane_c, mc2);
    end
    hold_y = lane_y;
    hold_c = lane_c;
    my2 = my1; my1 = py; mc2 = mc1; mc1 = pc;
    ty2 = ty1; ty1 = tgy; tc2 = tc1; tc1 = tgc;
    hq[4] = hq[3]; hq[3] = hq[2]; hq[2] = hq[1]; hq[1] = h;
    stb = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (mode) begin
      chk(tg1, lane_y, e1);
    end else begin
      chk("R2", lane_y, hold_y);
      chk("R2", lane_c, hold_c);
    end
  endtask

  task automatic line(input int blen, input int alen, input logic v, input logic f);
    for (int i = 0; i < blen; i++) pix(1'b0, v, f);
    for (int i = 0; i < alen; i++) pix(1'b1, v, f);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stb = 1'b0;
    y = '0; cb = '0; cr = '0; href = 1'b0; vref = 1'b0; fref = 1'b0;
    mode = 1'b0; ref_en = 1'b1; blank_en = 1'b1;
    blank_y = 10'h050; blank_c = 10'h1F0;
    for (int i = 1; i <= 4; i++) hq[i] = 1'b0;
    mpar = 1'b1; my1 = RY; my2 = RY; mc1 = RC; mc2 = RC;
    ty1 = "R13"; ty2 = "R13"; tc1 = "R13"; tc2 = "R13";
    lf = 1'b0; lv = 1'b0; lfsr = 16'hACE1; dcnt = 0;
    repeat (3) @(negedge clk);
    chk("R13", lane_y, RY);
    chk("R13", lane_c, RC);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", lane_y, RY);
    chk("R13", lane_c, RC);
    // two-lane mode, fill codes on, odd and even lines
    line(6, 5, 1'b1, 1'b0);
    line(6, 4, 1'b1, 1'b0);
    line(6, 3, 1'b0, 1'b0);
    // multiplexed mode with codes, all F/V combinations
    mode = 1'b1;
    line(6, 4, 1'b1, 1'b0);
    line(6, 5, 1'b0, 1'b0);
    line(6, 6, 1'b1, 1'b1);
    line(6, 3, 1'b0, 1'b1);
    line(5, 1, 1'b1, 1'b1);
    // multiplexed, no codes, raw blanking
    ref_en = 1'b0; blank_en = 1'b0;
    line(6, 5, 1'b1, 1'b0);
    line(6, 4, 1'b0, 1'b1);
    // two-lane mode, raw blanking
    mode = 1'b0;
    line(6, 5, 1'b1, 1'b0);
    line(6, 0, 1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule